// File: doc/BRIEF.md
# Moving Inversion Memory Test Engine

This block is a self-running test sequencer for a synchronous single-port memory. It drives the memory's address, write data, write enable and read enable, and checks the read data. Read data is expected one cycle after a read request. A single start pulse launches a complete test, and a two-bit mode input selects one of three algorithms: a moving inversion with fixed all-ones and all-zeros patterns, a moving inversion that uses pseudo-random data, or a short random sequence over the lowest few locations.

All passes walk the address space downward, from the highest address to address zero. Pseudo-random words come from a maximal-length Galois LFSR as wide as the data word. A seed input loads the LFSR, and the seed is kept. When the test reaches its verify pass, the LFSR is reloaded from the kept seed, so it reproduces the same values in the same address order. The first mismatch stops the test. The engine then reports done and fail, and holds the failing address, the expected word and the observed word until the next start.

Top module: `march_test_engine`

## Requirements
- R1: While reset is high and after it is released, busy, done and fail read 0 and neither mem_we nor mem_re is asserted until a start is accepted.
- R2: A start pulse is accepted only while busy is low. A start, mode or seed presented while busy is high does not change the running test or its result.
- R3: Mode 2'b00 (and the unused code 2'b11) runs the fixed pattern test. Every location is written with all ones. A zero fill pass then reads each location, expects all ones, and writes zeros. A ones fill pass then reads each location, expects zeros, and writes ones. A final pass reads each location and expects ones. A passing run leaves every location all ones.
- R4: Each pass starts at the top address and decrements by one down to 0. The top address is DEPTH-1, or NLOC-1 in sequence mode, so the first write after a start goes to the top address.
- R5: mem_re and mem_we are never high in the same cycle. Every access uses an address below DEPTH. mem_rdata is compared in the cycle after the read request.
- R6: The LFSR steps as next = v[0] ? (v>>1) ^ 8'hB8 : v>>1 for 8-bit words. A zero seed is replaced by all ones. The first random location (the top address) receives the resolved seed, and each later location receives the next LFSR state.
- R7: Mode 2'b01 writes all ones everywhere. It then visits each location top-down, checks for ones, and writes the next LFSR word. It then reloads the seed and verifies every location against the regenerated sequence.
- R8: Mode 2'b10 writes LFSR words to addresses NLOC-1 down to 0 and then verifies them with the reloaded sequence. No other location is written.
- R9: The first mismatch ends the test with done and fail high. fail_addr, fail_exp and fail_obs hold the location, the expected word and the read word. No memory access follows the mismatch.
- R10: When a test finishes, done stays high and busy stays low until the next accepted start. fail, done and the captured fields clear when that start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to launch a test |
| mode | input | 2 | Algorithm select: 0 fixed, 1 random inversion, 2 random sequence |
| seed | input | DATA_W | LFSR seed, sampled at start |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| fail | output | 1 | Mismatch found |
| fail_addr | output | ADDR_W | Address of the mismatch |
| fail_exp | output | DATA_W | Expected word at the mismatch |
| fail_obs | output | DATA_W | Word read at the mismatch |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_re |

## Verification
The bench attaches a behavioural memory that can inject a stuck-at-0 or stuck-at-1 bit at a chosen address. Each mode is run on a fault-free memory, and the resulting memory image is compared with the image the requirement predicts.

The faults are placed so that each one is caught by a different pass:
- A stuck-at-0 bit is caught by the first read in the zero fill.
- A stuck-at-1 bit under fixed data is caught only by the ones fill.
- A stuck-at-1 bit on a zero bit of a random word is caught only by the reloaded verify.
- A fault above NLOC must go unseen in sequence mode.

Directed runs cover a zero seed, a start issued mid-run, and done held after a test. A write-order monitor distinguishes a downward walk from any other address order.

// File: rtl/mte_pkg.sv
package mte_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_SEQW,
        PH_FILLA,
        PH_FILLB,
        PH_CHECK,
        PH_DONE
    } phase_e;

    localparam logic [1:0] MODE_FIXED = 2'd0;
    localparam logic [1:0] MODE_RAND  = 2'd1;
    localparam logic [1:0] MODE_SEQ   = 2'd2;

    // Galois feedback masks (right-shifting) for maximal-length sequences
    function automatic logic [63:0] lfsr_mask(input int unsigned w);
        case (w)
            4:       return 64'hC;
            8:       return 64'hB8;
            12:      return 64'hE08;
            16:      return 64'hB400;
            24:      return 64'hE1_0000;
            32:      return 64'h8020_0003;
            64:      return 64'hD800_0000_0000_0000;
            default: return 64'h1 << (w - 1);
        endcase
    endfunction

    function automatic logic [63:0] lfsr_step(input logic [63:0] s, input int unsigned w);
        return s[0] ? ((s >> 1) ^ lfsr_mask(w)) : (s >> 1);
    endfunction

endpackage

// File: rtl/mte_lfsr.sv
module mte_lfsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] value
);
    import mte_pkg::*;

    logic [W-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '1;
        else if (load)
            st_q <= (seed == '0) ? '1 : seed;
        else if (adv)
            st_q <= W'(lfsr_step(64'(st_q), W));
    end

    assign value = st_q;

    // R6: a zero state would lock the generator
    p_state_nonzero_r6: assert property (@(posedge clk) disable iff (rst) st_q != '0);
endmodule

// File: rtl/mte_addr_ctr.sv
module mte_addr_ctr #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] top,
    input  logic          dec,
    output logic [AW-1:0] cnt,
    output logic          last
);
    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= top;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == '0);

    // R4: addresses only ever step downward by one
    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mte_fail_capture.sv
module mte_fail_capture #(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  exp_d,
    input  logic [W-1:0]  obs_d,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [W-1:0]  fail_exp,
    output logic [W-1:0]  fail_obs
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_obs  <= '0;
        end else if (cap) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= exp_d;
            fail_obs  <= obs_d;
        end
    end

    // R9: captured record is held until cleared or recaptured
    p_hold_record_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !cap) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_obs) && $stable(fail)));
endmodule

// File: rtl/march_test_engine.sv
module march_test_engine #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int NLOC   = 5,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] seed,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_obs,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);
    import mte_pkg::*;

    localparam logic [ADDR_W-1:0] TOP_FULL = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] TOP_SEQ  = ADDR_W'(NLOC - 1);
    localparam logic [DATA_W-1:0] ONES     = '1;
    localparam logic [DATA_W-1:0] ZEROS    = '0;

    phase_e            phase_q, phase_d;
    logic              step_q;
    logic [1:0]        mode_q;
    logic [DATA_W-1:0] seed_q;

    logic              accept, cmp_phase, use_rand, mismatch, pass_ok;
    logic              addr_dec, addr_load, last, pass_end;
    logic              lfsr_load, lfsr_adv;
    logic [ADDR_W-1:0] top_addr;
    logic [DATA_W-1:0] rnd, exp_data, wr_data;

    assign busy      = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
    assign done      = (phase_q == PH_DONE);
    assign accept    = start && !busy;
    assign use_rand  = (mode_q == MODE_RAND) || (mode_q == MODE_SEQ);
    assign cmp_phase = (phase_q == PH_FILLA) || (phase_q == PH_FILLB) || (phase_q == PH_CHECK);

    always_comb begin
        exp_data = ONES;
        wr_data  = ZEROS;
        case (phase_q)
            PH_INIT:  wr_data = ONES;
            PH_SEQW:  wr_data = rnd;
            PH_FILLA: begin exp_data = ONES;  wr_data = use_rand ? rnd : ZEROS; end
            PH_FILLB: begin exp_data = ZEROS; wr_data = ONES; end
            PH_CHECK: exp_data = use_rand ? rnd : ONES;
            default:  ;
        endcase
    end

    assign mismatch = cmp_phase && step_q && (mem_rdata != exp_data);
    assign pass_ok  = cmp_phase && step_q && !mismatch;
    assign addr_dec = (phase_q == PH_INIT) || (phase_q == PH_SEQW) || pass_ok;
    assign pass_end = addr_dec && last;
    assign lfsr_adv = (phase_q == PH_SEQW) ||
                      (pass_ok && use_rand && (phase_q == PH_FILLA || phase_q == PH_CHECK));

    assign mem_re    = cmp_phase && !step_q;
    assign mem_we    = (phase_q == PH_INIT) || (phase_q == PH_SEQW) || (pass_ok && phase_q != PH_CHECK);
    assign mem_wdata = wr_data;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE, PH_DONE:
                if (accept) phase_d = (mode == MODE_SEQ) ? PH_SEQW : PH_INIT;
            PH_INIT:  if (pass_end) phase_d = PH_FILLA;
            PH_SEQW:  if (pass_end) phase_d = PH_CHECK;
            PH_FILLA: if (mismatch) phase_d = PH_DONE;
                      else if (pass_end) phase_d = use_rand ? PH_CHECK : PH_FILLB;
            PH_FILLB: if (mismatch) phase_d = PH_DONE;
                      else if (pass_end) phase_d = PH_CHECK;
            PH_CHECK: if (mismatch || pass_end) phase_d = PH_DONE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    assign addr_load = accept || (pass_end && phase_d != PH_DONE);
    assign top_addr  = ((accept ? mode : mode_q) == MODE_SEQ) ? TOP_SEQ : TOP_FULL;
    assign lfsr_load = accept || (pass_end && phase_d == PH_CHECK);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= 1'b0;
            mode_q  <= MODE_FIXED;
            seed_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= cmp_phase && !step_q && !accept;
            if (accept) begin
                mode_q <= mode;
                seed_q <= seed;
            end
        end
    end

    mte_addr_ctr #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(addr_load), .top(top_addr),
        .dec(addr_dec), .cnt(mem_addr), .last(last)
    );

    mte_lfsr #(.W(DATA_W)) u_lfsr (
        .clk(clk), .rst(rst), .load(lfsr_load),
        .seed(accept ? seed : seed_q), .adv(lfsr_adv), .value(rnd)
    );

    mte_fail_capture #(.AW(ADDR_W), .W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .clr(accept), .cap(mismatch),
        .addr(mem_addr), .exp_d(exp_data), .obs_d(mem_rdata),
        .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
    );

    // R5: one memory operation per cycle, always in range
    p_rw_excl_r5: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re));
    p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (32'(mem_addr) < DEPTH));
    // R9: a mismatch ends the run with the failure flagged
    p_stop_on_miss_r9: assert property (@(posedge clk) disable iff (rst) mismatch |=> (done && fail));
    p_fail_done_r9: assert property (@(posedge clk) disable iff (rst) fail |-> done);
    // R10: done and busy are exclusive, done follows a busy run
    p_busy_done_r10: assert property (@(posedge clk) disable iff (rst) !(busy && done));
    p_done_after_run_r10: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> $past(busy));
endmodule

// File: tb/march_test_engine_test.sv
module march_test_engine_test;
    localparam int DW = 8;
    localparam int DEP = 16;
    localparam int NL = 5;
    localparam int AW = 4;

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] seed;
        logic [1:0] fk;     // 0 none, 1 stuck-at-0, 2 stuck-at-1
        logic [3:0] fa;
        logic [2:0] fb;
        logic       ef;
        logic [3:0] ea;
        logic [7:0] ee;
        logic [7:0] eo;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h00, 2'd0, 4'd0,  3'd0, 1'b0, 4'd0, 8'h00, 8'h00},
        '{2'd0, 8'h00, 2'd2, 4'd5,  3'd0, 1'b1, 4'd5, 8'h00, 8'h01},
        '{2'd0, 8'h00, 2'd1, 4'd9,  3'd7, 1'b1, 4'd9, 8'hFF, 8'h7F},
        '{2'd1, 8'h3C, 2'd0, 4'd0,  3'd0, 1'b0, 4'd0, 8'h00, 8'h00},
        '{2'd1, 8'hA5, 2'd1, 4'd9,  3'd7, 1'b1, 4'd9, 8'hFF, 8'h7F},
        '{2'd2, 8'h91, 2'd0, 4'd0,  3'd0, 1'b0, 4'd0, 8'h00, 8'h00},
        '{2'd2, 8'h91, 2'd1, 4'd12, 3'd3, 1'b0, 4'd0, 8'h00, 8'h00},
        '{2'd3, 8'h00, 2'd0, 4'd0,  3'd0, 1'b0, 4'd0, 8'h00, 8'h00}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [DW-1:0] seed = '0;
    logic busy, done, fail, mem_we, mem_re;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [DW-1:0] fail_exp, fail_obs, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #5 clk = ~clk;

    march_test_engine #(.DATA_W(DW), .DEPTH(DEP), .NLOC(NL)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .seed(seed),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_obs(fail_obs), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // behavioural memory with one injectable stuck bit
    logic [DW-1:0] mem [DEP];
    logic [1:0] fk = 2'd0;
    logic [3:0] fa = '0;
    logic [2:0] fb = '0;
    logic preload = 1'b0;

    function automatic logic [7:0] faulty(input logic [7:0] d, input logic [3:0] a);
        if (a == fa && fk == 2'd1) return d & ~(8'h1 << fb);
        if (a == fa && fk == 2'd2) return d | (8'h1 << fb);
        return d;
    endfunction

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < DEP; i++) mem[i] <= 8'h5A;
        end else if (mem_we) begin
            mem[mem_addr] <= faulty(mem_wdata, mem_addr);
        end
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    // monitors: write order, first write, clashes, access after done
    int order_err = 0, clash = 0, late_acc = 0;
    logic have_prev = 1'b0, got_first = 1'b0;
    logic [3:0] prev_w = '0, first_w = '0, top_run = 4'd15;
    always @(posedge clk) begin
        if (!rst && mem_we && mem_re) clash <= clash + 1;
        if (!rst && done && (mem_we || mem_re)) late_acc <= late_acc + 1;
        if (preload) begin
            have_prev <= 1'b0;
            got_first <= 1'b0;
        end else if (mem_we) begin
            if (!got_first) begin first_w <= mem_addr; got_first <= 1'b1; end
            if (have_prev && !(mem_addr == prev_w - 4'd1 || mem_addr == top_run))
                order_err <= order_err + 1;
            prev_w <= mem_addr;
            have_prev <= 1'b1;
        end
    end

    int checks = 0, errors = 0, cyc = 0;

    task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] v);
        return v[0] ? ((v >> 1) ^ 8'hB8) : (v >> 1);
    endfunction

    // expected image after a clean run; returns number of wrong words
    function automatic int image_err(input logic [1:0] md, input logic [7:0] sd);
        int n = 0;
        logic [7:0] v = (sd == 8'h00) ? 8'hFF : sd;
        for (int a = DEP - 1; a >= 0; a--) begin
            logic [7:0] e;
            if (md == 2'd1) begin e = v; v = nxt(v); end
            else if (md == 2'd2) begin
                if (a < NL) begin e = v; v = nxt(v); end else e = 8'h5A;
            end else e = 8'hFF;
            if (mem[a] !== e) n++;
        end
        return n;
    endfunction

    task automatic run(input logic [1:0] md, input logic [7:0] sd,
                       input logic [1:0] k, input logic [3:0] a, input logic [2:0] b);
        @(negedge clk);
        fk = k; fa = a; fb = b;
        top_run = (md == 2'd2) ? 4'(NL - 1) : 4'(DEP - 1);
        preload = 1'b1;
        @(negedge clk);
        preload = 1'b0;
        mode = md; seed = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        check("R10 run finishes", done, 32'(done), 1);
    endtask

    initial begin
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and after reset
        check("R1 reset busy/done/fail", !busy && !done && !fail, {busy, done, fail}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", !busy && !done && !fail && !mem_we && !mem_re,
              {busy, done, fail, mem_we, mem_re}, 0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i].mode, VEC[i].seed, VEC[i].fk, VEC[i].fa, VEC[i].fb);
            check("R10 busy after start", busy && !done && !fail, {busy, done, fail}, 3'b100);
            wait_done();
            check("R9 fail flag", fail == VEC[i].ef, 32'(fail), 32'(VEC[i].ef));
            if (VEC[i].ef) begin
                check("R9 fail address", fail_addr == VEC[i].ea, 32'(fail_addr), 32'(VEC[i].ea));
                check("R9 fail expected", fail_exp == VEC[i].ee, 32'(fail_exp), 32'(VEC[i].ee));
                check("R9 fail observed", fail_obs == VEC[i].eo, 32'(fail_obs), 32'(VEC[i].eo));
            end else if (VEC[i].mode == 2'd1) begin
                check("R7 random image", image_err(2'd1, VEC[i].seed) == 0, image_err(2'd1, VEC[i].seed), 0);
            end else if (VEC[i].mode == 2'd2) begin
                check("R8 sequence image", image_err(2'd2, VEC[i].seed) == 0, image_err(2'd2, VEC[i].seed), 0);
            end else begin
                check("R3 fixed image", image_err(2'd0, 8'h00) == 0, image_err(2'd0, 8'h00), 0);
            end
            check("R4 first write at top", first_w == top_run, 32'(first_w), 32'(top_run));
            check("R4 descending order", order_err == 0, order_err, 0);
            check("R5 no read/write clash", clash == 0, clash, 0);
        end

        // R9: no memory access after the stop
        check("R9 quiet after done", late_acc == 0, late_acc, 0);

        // R6: zero seed becomes all ones at the top address
        run(2'd1, 8'h00, 2'd0, 4'd0, 3'd0);
        wait_done();
        check("R6 zero seed top word", mem[15] == 8'hFF, 32'(mem[15]), 32'hFF);
        check("R6 second word", mem[14] == nxt(8'hFF), 32'(mem[14]), 32'(nxt(8'hFF)));

        // R7: a stuck-at-1 on a zero bit of a random word is caught by the reloaded verify
        begin
            logic [7:0] vals [16];
            logic [7:0] v = 8'h3C;
            int ta;
            int bb = 0;
            for (int a = 15; a >= 0; a--) begin vals[a] = v; v = nxt(v); end
            ta = (vals[3] != 8'hFF) ? 3 : 4;
            while (vals[ta][bb]) bb++;
            run(2'd1, 8'h3C, 2'd2, 4'(ta), 3'(bb));
            wait_done();
            check("R7 verify catches fault", fail && fail_addr == 4'(ta), {fail, fail_addr}, {1'b1, 4'(ta)});
            check("R7 expected regenerated", fail_exp == vals[ta], 32'(fail_exp), 32'(vals[ta]));
            check("R7 observed word", fail_obs == (vals[ta] | (8'h1 << bb)),
                  32'(fail_obs), 32'(vals[ta] | (8'h1 << bb)));
        end

        // R10: fail clears on next start; done held after completion
        run(2'd0, 8'h00, 2'd0, 4'd0, 3'd0);
        check("R10 fail cleared at start", !fail && !done && busy, {fail, done, busy}, 3'b001);
        // R2: start with another mode while busy is ignored
        repeat (20) @(negedge clk);
        mode = 2'd1; seed = 8'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R2 mid-run start ignored", !fail && image_err(2'd0, 8'h00) == 0, image_err(2'd0, 8'h00), 0);
        repeat (10) @(negedge clk);
        check("R10 done held", done && !busy, {done, busy}, 2'b10);
        check("R5 no clash overall", clash == 0, clash, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule